// File: doc/BRIEF.md
# Panel Temperature Threshold Monitor

This block is the digital side of a panel temperature monitor. It asks an external converter for a sample through a start/done handshake. It then limits the returned signed Celsius code to the supported span and keeps it as the latest reading. The reading is compared with a hot limit and a cool limit. Hot readings pass through a counting queue, so the hot flag is raised only after a selectable number of hot results. Any reading below the hot limit resets that count.

An acquisition starts in one of two ways. The host can pulse a command input, and the matching busy output then reads back as a command bit that clears itself. A periodic timer can also start one after a fixed number of 1 ms ticks. Three sticky flags are kept: hot, cool and end of conversion. Reading the status clears them. Each flag has its own enable into a single interrupt line. A separate conversion-complete level shows whether the most recent acquisition has finished.

Top module: `thermal_watch`

## Requirements
- R1: After reset, `temp_last` is 0x00, all three flags, `read_busy`, `conv_end`, `adc_start` and `irq` are 0, the hot limit is 0x32 (50 °C) and the cool limit is 0x2D (45 °C).
- R2: When idle, a `read_cmd` pulse makes `adc_start` high for exactly the following cycle, with `read_busy` set. `read_busy` stays high until a cycle in which `adc_done` is high. At that edge, `read_busy` clears and `conv_end` sets. `conv_end` clears again when the next acquisition is launched.
- R3: A start request (from `read_cmd` or the timer) that arrives while `read_busy` is high is ignored: no `adc_start` follows it.
- R4: `adc_code` is a two's-complement Celsius value. The stored `temp_last` is that value limited to the range -10 (0xF6) to 85 (0x55).
- R5: The comparison with the hot limit is signed and uses the limited reading. A reading equal to the hot limit counts as hot.
- R6: `queue_sel` gives the number of consecutive hot readings needed to set `flag_hot`: 0 needs 1, 1 needs 2, 2 needs 4, 3 needs 6. Each further hot reading sets it again.
- R7: The hot count returns to zero on any reading below the hot limit. It also returns to zero on a `queue_clr` pulse.
- R8: A reading strictly below the cool limit (signed) sets `flag_cool`.
- R9: Every completed conversion sets `flag_eoc`.
- R10: Flags are sticky. A `status_rd` pulse clears all three at the next edge, unless a conversion completing in the same cycle sets one again.
- R11: `irq` is high exactly when some flag is set with its enable high (`hot_ie`, `cool_ie`, `eoc_ie`). It follows the flags and enables in the same cycle.
- R12: While `periodic_en` is high, every PERIOD_MS-th `tick_ms` pulse launches an acquisition. With `periodic_en` low, the tick count is held at zero.
- R13: A `hot_wr` or `cool_wr` pulse loads `limit_data` into the hot or cool limit. The new limit is used from the next conversion on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | 1 ms time base pulse |
| periodic_en | input | 1 | Enables timed acquisitions |
| read_cmd | input | 1 | Host start request pulse |
| adc_start | output | 1 | One-cycle start to the converter |
| adc_done | input | 1 | Converter result valid |
| adc_code | input | 8 | Signed Celsius result from converter |
| hot_wr | input | 1 | Load hot limit |
| cool_wr | input | 1 | Load cool limit |
| limit_data | input | 8 | Signed limit value to load |
| queue_sel | input | 2 | Hot readings needed: 1, 2, 4 or 6 |
| queue_clr | input | 1 | Clears the hot count |
| status_rd | input | 1 | Status read; clears sticky flags |
| hot_ie | input | 1 | Hot flag interrupt enable |
| cool_ie | input | 1 | Cool flag interrupt enable |
| eoc_ie | input | 1 | End-of-conversion interrupt enable |
| read_busy | output | 1 | Acquisition in progress (self-clearing command bit) |
| conv_end | output | 1 | Last acquisition complete |
| temp_last | output | 8 | Latest limited reading |
| flag_hot | output | 1 | Sticky hot flag |
| flag_cool | output | 1 | Sticky cool flag |
| flag_eoc | output | 1 | Sticky end-of-conversion flag |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong hot count appears only on `flag_hot`, one edge after the completing conversion. It shows as either an early flag before the selected number of hot readings or a missing flag when the count has been reached. The queue sweep therefore samples the flag after every single reading. A bad limit, or a signed/unsigned mix-up, shows on `temp_last` or on a flag in the cycle after `adc_done`. A stuck busy bit shows as a missing `adc_start` on the next request.

// File: rtl/thermal_watch_pkg.sv
package thermal_watch_pkg;
  localparam int TEMP_W = 8;
  localparam int RUN_W  = 3;
  localparam int NFLAG  = 3;
  localparam int IDX_HOT  = 0;
  localparam int IDX_COOL = 1;
  localparam int IDX_EOC  = 2;
  localparam logic signed [TEMP_W-1:0] T_LOW  = -8'sd10;
  localparam logic signed [TEMP_W-1:0] T_HIGH = 8'sd85;
  localparam logic [TEMP_W-1:0] HOT_RST  = 8'h32;
  localparam logic [TEMP_W-1:0] COOL_RST = 8'h2D;

  function automatic logic [TEMP_W-1:0] clamp_temp(input logic [TEMP_W-1:0] raw);
    logic signed [TEMP_W-1:0] s;
    s = $signed(raw);
    if (s > T_HIGH)     return T_HIGH;
    else if (s < T_LOW) return T_LOW;
    else                return raw;
  endfunction

  function automatic logic [RUN_W-1:0] queue_need(input logic [1:0] sel);
    case (sel)
      2'd0:    return RUN_W'(1);
      2'd1:    return RUN_W'(2);
      2'd2:    return RUN_W'(4);
      default: return RUN_W'(6);
    endcase
  endfunction

  function automatic logic at_or_above(input logic [TEMP_W-1:0] a, input logic [TEMP_W-1:0] b);
    return $signed(a) >= $signed(b);
  endfunction
endpackage

// File: rtl/tw_launch.sv
module tw_launch #(
  parameter int PERIOD_MS = 60000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_ms,
  input  logic periodic_en,
  input  logic read_cmd,
  input  logic adc_done,
  output logic adc_start,
  output logic busy,
  output logic conv_end,
  output logic take,
  output logic timer_fire
);
  localparam int CNT_W = (PERIOD_MS > 1) ? $clog2(PERIOD_MS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERIOD_MS - 1);

  logic [CNT_W-1:0] tick_cnt;
  logic launch;

  assign timer_fire = periodic_en && tick_ms && (tick_cnt == CNT_LAST);
  assign launch     = (read_cmd || timer_fire) && !busy;
  assign take       = busy && adc_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt <= '0;
    end else if (!periodic_en) begin
      tick_cnt <= '0;
    end else if (tick_ms) begin
      tick_cnt <= (tick_cnt == CNT_LAST) ? '0 : tick_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      adc_start <= 1'b0;
      conv_end  <= 1'b0;
    end else begin
      adc_start <= launch;
      if (launch) begin
        busy     <= 1'b1;
        conv_end <= 1'b0;
      end else if (take) begin
        busy     <= 1'b0;
        conv_end <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tw_judge.sv
module tw_judge
  import thermal_watch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [TEMP_W-1:0] adc_code,
  input  logic              hot_wr,
  input  logic              cool_wr,
  input  logic [TEMP_W-1:0] limit_data,
  input  logic [1:0]        queue_sel,
  input  logic              queue_clr,
  input  logic              status_rd,
  output logic [TEMP_W-1:0] temp_last,
  output logic [NFLAG-1:0]  flags,
  output logic [RUN_W-1:0]  hot_run
);
  localparam logic [RUN_W-1:0] RUN_CAP = RUN_W'(6);

  logic [TEMP_W-1:0] hot_lim, cool_lim, sample;
  logic [RUN_W-1:0]  run_next;
  logic              is_hot, is_cool;
  logic [NFLAG-1:0]  flag_set;

  assign sample   = clamp_temp(adc_code);
  assign is_hot   = at_or_above(sample, hot_lim);
  assign is_cool  = !at_or_above(sample, cool_lim);
  assign run_next = (hot_run == RUN_CAP) ? RUN_CAP : hot_run + 1'b1;

  assign flag_set[IDX_HOT]  = take && is_hot && (run_next >= queue_need(queue_sel));
  assign flag_set[IDX_COOL] = take && is_cool;
  assign flag_set[IDX_EOC]  = take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hot_lim  <= HOT_RST;
      cool_lim <= COOL_RST;
    end else begin
      if (hot_wr)  hot_lim  <= limit_data;
      if (cool_wr) cool_lim <= limit_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      temp_last <= '0;
      hot_run   <= '0;
    end else if (take) begin
      temp_last <= sample;
      hot_run   <= is_hot ? run_next : '0;
    end else if (queue_clr) begin
      hot_run   <= '0;
    end
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) flags[g] <= 1'b0;
      else        flags[g] <= flag_set[g] || (flags[g] && !status_rd);
    end
  end
endmodule

// File: rtl/thermal_watch.sv
module thermal_watch
  import thermal_watch_pkg::*;
#(
  parameter int PERIOD_MS = 60000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       periodic_en,
  input  logic       read_cmd,
  output logic       adc_start,
  input  logic       adc_done,
  input  logic [7:0] adc_code,
  input  logic       hot_wr,
  input  logic       cool_wr,
  input  logic [7:0] limit_data,
  input  logic [1:0] queue_sel,
  input  logic       queue_clr,
  input  logic       status_rd,
  input  logic       hot_ie,
  input  logic       cool_ie,
  input  logic       eoc_ie,
  output logic       read_busy,
  output logic       conv_end,
  output logic [7:0] temp_last,
  output logic       flag_hot,
  output logic       flag_cool,
  output logic       flag_eoc,
  output logic       irq
);
  logic             sample_take;
  logic             timer_fire;
  logic [NFLAG-1:0] flags;
  logic [NFLAG-1:0] enables;
  logic [RUN_W-1:0] hot_run;

  tw_launch #(.PERIOD_MS(PERIOD_MS)) u_launch (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .periodic_en(periodic_en),
    .read_cmd(read_cmd), .adc_done(adc_done), .adc_start(adc_start),
    .busy(read_busy), .conv_end(conv_end), .take(sample_take),
    .timer_fire(timer_fire)
  );

  tw_judge u_judge (
    .clk(clk), .rst_n(rst_n), .take(sample_take), .adc_code(adc_code),
    .hot_wr(hot_wr), .cool_wr(cool_wr), .limit_data(limit_data),
    .queue_sel(queue_sel), .queue_clr(queue_clr), .status_rd(status_rd),
    .temp_last(temp_last), .flags(flags), .hot_run(hot_run)
  );

  assign enables[IDX_HOT]  = hot_ie;
  assign enables[IDX_COOL] = cool_ie;
  assign enables[IDX_EOC]  = eoc_ie;

  assign flag_hot  = flags[IDX_HOT];
  assign flag_cool = flags[IDX_COOL];
  assign flag_eoc  = flags[IDX_EOC];
  assign irq       = |(flags & enables);
endmodule

// File: rtl/thermal_watch_checks.sv
module thermal_watch_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       adc_start,
  input logic       read_busy,
  input logic       sample_take,
  input logic       status_rd,
  input logic [7:0] temp_last,
  input logic [2:0] hot_run,
  input logic       flag_hot,
  input logic       flag_cool,
  input logic       flag_eoc
);
  // R2: a launch always coincides with the busy bit
  assert_launch_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> read_busy);

  // R3: no second launch while the first is outstanding
  assert_single_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  // R4: stored reading stays inside the limited span
  assert_temp_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(temp_last) >= -8'sd10) && ($signed(temp_last) <= 8'sd85));

  // R6: hot count saturates at the largest queue depth
  assert_run_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hot_run <= 3'd6);

  // R5: hot flag only rises after a completed sample
  assert_hot_from_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_hot) |-> $past(sample_take));

  // R9: end-of-conversion flag only rises after a completed sample
  assert_eoc_from_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_eoc) |-> $past(sample_take));

  // R10: status read without a concurrent sample leaves all flags clear
  assert_clear_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !sample_take) |=> (!flag_hot && !flag_cool && !flag_eoc));
endmodule

bind thermal_watch thermal_watch_checks u_checks (.*);

// File: tb/thermal_watch_test.sv
module thermal_watch_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b0, periodic_en = 1'b0, read_cmd = 1'b0, adc_done = 1'b0;
  logic [7:0] adc_code = 8'h00, limit_data = 8'h00;
  logic hot_wr = 1'b0, cool_wr = 1'b0, queue_clr = 1'b0, status_rd = 1'b0;
  logic [1:0] queue_sel = 2'd0;
  logic hot_ie = 1'b0, cool_ie = 1'b0, eoc_ie = 1'b0;
  logic adc_start, read_busy, conv_end, flag_hot, flag_cool, flag_eoc, irq;
  logic [7:0] temp_last;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  thermal_watch #(.PERIOD_MS(5)) uut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .periodic_en(periodic_en),
    .read_cmd(read_cmd), .adc_start(adc_start), .adc_done(adc_done),
    .adc_code(adc_code), .hot_wr(hot_wr), .cool_wr(cool_wr),
    .limit_data(limit_data), .queue_sel(queue_sel), .queue_clr(queue_clr),
    .status_rd(status_rd), .hot_ie(hot_ie), .cool_ie(cool_ie), .eoc_ie(eoc_ie),
    .read_busy(read_busy), .conv_end(conv_end), .temp_last(temp_last),
    .flag_hot(flag_hot), .flag_cool(flag_cool), .flag_eoc(flag_eoc), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int limited(input logic [7:0] c);
    int v;
    v = int'($signed(c));
    if (v > 85) v = 85;
    if (v < -10) v = -10;
    return v;
  endfunction

  // full handshake; leaves outputs settled after the completing edge
  task automatic convert(input logic [7:0] code);
    @(negedge clk); read_cmd = 1'b1;
    @(posedge clk); #1;
    check(adc_start && read_busy, "R2 launch", int'(adc_start), 1);
    @(negedge clk); read_cmd = 1'b0; adc_done = 1'b1; adc_code = code;
    @(posedge clk); #1;
    @(negedge clk); adc_done = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk); status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); queue_clr = 1'b1;
    @(negedge clk); queue_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset values
    check(temp_last == 8'h00 && !flag_hot && !flag_cool && !flag_eoc,
          "R1 outputs", int'(temp_last), 0);
    check(!read_busy && !conv_end && !adc_start && !irq, "R1 control", int'(read_busy), 0);

    // R2 handshake details, R3 ignored request while busy
    @(negedge clk); read_cmd = 1'b1;
    @(negedge clk); read_cmd = 1'b1;
    @(posedge clk); #1;
    check(!adc_start, "R3 ignored start", int'(adc_start), 0);
    check(read_busy && !conv_end, "R2 busy held", int'(read_busy), 1);
    @(negedge clk); read_cmd = 1'b0; adc_done = 1'b1; adc_code = 8'h19;
    @(posedge clk); #1;
    check(!read_busy && conv_end, "R2 done clears busy", int'(read_busy), 0);
    check(flag_eoc, "R9 eoc set", int'(flag_eoc), 1);
    check(temp_last == 8'h19, "R4 in range", int'(temp_last), 25);
    @(negedge clk); adc_done = 1'b0;
    @(negedge clk); read_cmd = 1'b1;
    @(posedge clk); #1;
    check(!conv_end, "R2 conv_end clears on launch", int'(conv_end), 0);
    @(negedge clk); read_cmd = 1'b0; adc_done = 1'b1; adc_code = 8'h00;
    @(negedge clk); adc_done = 1'b0;
    clear_flags();
    @(posedge clk); #1;
    check(!flag_eoc && !flag_cool && !flag_hot, "R10 cleared", int'(flag_eoc), 0);

    // R4 R5 R8 sweep over every code with default limits and queue depth 1
    for (int c = 0; c < 256; c++) begin
      int exp_t;
      convert(8'(c));
      exp_t = limited(8'(c));
      check(int'($signed(temp_last)) == exp_t, "R4 limit", int'($signed(temp_last)), exp_t);
      check(flag_hot == (exp_t >= 50), "R5 hot compare", int'(flag_hot), int'(exp_t >= 50));
      check(flag_cool == (exp_t < 45), "R8 cool compare", int'(flag_cool), int'(exp_t < 45));
      clear_flags();
    end

    // R6 R7 queue depths
    for (int s = 0; s < 4; s++) begin
      int need;
      need = (s == 0) ? 1 : (s == 1) ? 2 : (s == 2) ? 4 : 6;
      queue_sel = 2'(s);
      pulse_clr();
      for (int k = 1; k <= need; k++) begin
        convert(8'h3C);
        check(flag_hot == (k == need), "R6 queue count", int'(flag_hot), int'(k == need));
        clear_flags();
      end
      convert(8'h3C);
      check(flag_hot, "R6 repeat after reach", int'(flag_hot), 1);
      clear_flags();
      convert(8'h14);
      clear_flags();
      for (int k = 1; k < need; k++) convert(8'h3C);
      check(!flag_hot || need == 1, "R7 reset by cool reading", int'(flag_hot), 0);
      clear_flags();
      pulse_clr();
      convert(8'h3C);
      check(flag_hot == (need == 1), "R7 reset by clear", int'(flag_hot), int'(need == 1));
      clear_flags();
    end
    queue_sel = 2'd0;

    // R13 limit writes, signed equality
    @(negedge clk); hot_wr = 1'b1; limit_data = 8'hF8;
    @(negedge clk); hot_wr = 1'b0; cool_wr = 1'b1; limit_data = 8'h00;
    @(negedge clk); cool_wr = 1'b0;
    convert(8'hF7);
    check(!flag_hot && flag_cool, "R13 below new hot, below cool", int'(flag_hot), 0);
    clear_flags();
    convert(8'hF8);
    check(flag_hot, "R13 R5 equal counts hot", int'(flag_hot), 1);
    clear_flags();
    convert(8'h00);
    check(!flag_cool, "R13 R8 equal not cool", int'(flag_cool), 0);
    clear_flags();
    @(negedge clk); hot_wr = 1'b1; limit_data = 8'h32;
    @(negedge clk); hot_wr = 1'b0; cool_wr = 1'b1; limit_data = 8'h2D;
    @(negedge clk); cool_wr = 1'b0;

    // R11 interrupt gating: eoc and cool set, hot clear
    convert(8'h14);
    @(negedge clk); hot_ie = 1'b1; #1;
    check(!irq, "R11 hot only", int'(irq), 0);
    cool_ie = 1'b1; #1;
    check(irq, "R11 cool enabled", int'(irq), 1);
    cool_ie = 1'b0; hot_ie = 1'b0; eoc_ie = 1'b1; #1;
    check(irq, "R11 eoc enabled", int'(irq), 1);
    eoc_ie = 1'b0; #1;
    check(!irq, "R11 none enabled", int'(irq), 0);
    eoc_ie = 1'b1;
    clear_flags();
    #1;
    check(!irq, "R10 R11 read clears irq", int'(irq), 0);
    eoc_ie = 1'b0;

    // R10 set wins over a simultaneous read
    @(negedge clk); read_cmd = 1'b1;
    @(negedge clk); read_cmd = 1'b0; adc_done = 1'b1; adc_code = 8'h14; status_rd = 1'b1;
    @(negedge clk); adc_done = 1'b0; status_rd = 1'b0;
    check(flag_eoc && flag_cool, "R10 set wins", int'(flag_eoc), 1);
    clear_flags();

    // R12 periodic launch after five ticks
    tick_ms = 1'b1;
    @(negedge clk); periodic_en = 1'b1;
    begin
      int n;
      n = 0;
      for (int k = 1; k <= 8; k++) begin
        @(posedge clk); #1;
        if (adc_start) begin n = k; break; end
      end
      check(n == 5, "R12 period", n, 5);
    end
    @(negedge clk); adc_done = 1'b1; adc_code = 8'h05; periodic_en = 1'b0;
    @(negedge clk); adc_done = 1'b0;
    check(temp_last == 8'h05 && conv_end, "R12 timed sample stored", int'(temp_last), 5);
    repeat (8) begin
      @(posedge clk); #1;
      check(!adc_start, "R12 disabled timer idle", int'(adc_start), 0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule